// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filter

This block turns an asynchronous serial line into parallel characters. A clock enable (`tick16`) pulses sixteen times per bit period. The receiver brings the line through a synchronizer and watches for a high-to-low transition, which starts a frame. It confirms the start bit at its midpoint. It then samples each later bit at its centre, so every data bit is taken sixteen ticks after the previous one.

A frame carries 8 or 9 data bits, least significant bit first. An even or odd parity bit may follow, then one or two stop bits. Each finished character goes into a two-entry holding buffer together with its own framing and parity error bits. A character that arrives while the buffer is full, or while the overrun flag is already set, is discarded and raises the overrun flag. The flag stays set until it is cleared. In 9-bit mode an optional filter drops every character whose top bit is clear. A node on a shared line can therefore ignore traffic until an address character arrives.

Top module: `uart_rx_os`

## Requirements
- R1: A low pulse on `rx` that is high again when sampled 8 ticks after the detected falling edge produces no character.
- R2: In 8-bit mode (`cfg_nine`=0) the first bit after start is `rd_data[0]`, the eighth is `rd_data[7]`, and `rd_data[8]` reads 0.
- R3: In 9-bit mode (`cfg_nine`=1) the ninth data bit received appears on `rd_data[8]`.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `rd_perr` is 1 when the count of ones over data plus parity bit is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1.
- R5: `rd_ferr` is 1 when a stop bit is sampled as 0. With `cfg_two_stop`=1 both stop bits are checked.
- R6: Up to two characters are held. `rd_valid` is 1 while at least one is held, the outputs show the oldest, and a one-cycle `rd_en` pulse removes it.
- R7: A character completing while two are held and `rd_en` is 0 is discarded and sets `ovr_flag`. While `ovr_flag` is 1 every new character is discarded. `ovr_clr` clears the flag.
- R8: With `cfg_addr_only`=1 and `cfg_nine`=1, a character whose `rd_data[8]` would be 0 is discarded without touching the buffer or `ovr_flag`. Characters with bit 8 set are kept.
- R9: After reset `rd_valid` and `ovr_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx | input | 1 | Serial line, idles high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_two_stop | input | 1 | Two stop bits expected |
| cfg_addr_only | input | 1 | Drop characters with bit 8 clear (9-bit mode) |
| rd_en | input | 1 | Remove oldest held character |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | At least one character held |
| rd_data | output | 9 | Oldest held character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| rd_perr | output | 1 | Parity error of the oldest character |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
A bit counter that slips by one shows up at the ports as a character that is shifted or has a wrong top bit. A phase that is off by a few ticks pushes sampling toward bit edges, and a bad stop sample shows as a false framing error. Both become visible at the end of the frame where they occur. A bad buffer pointer or count appears as the wrong `rd_valid`, reordered characters, or `ovr_flag` set too early or too late. These show on the third or fourth character of a burst. Each character is compared against the value the bench sent, and the overrun flag is compared after every frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 9;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    // Value the parity bit must take for the given data ones-count
    function automatic logic parity_expect(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick16,
    input  logic     rx_s,
    input  logic     cfg_nine,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    input  logic     cfg_two_stop,
    output logic     chr_valid,
    output rx_char_t chr
);
    localparam int PH_W     = 4;
    localparam int IDX_W    = $clog2(DATA_W + 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(7);
    localparam logic [PH_W-1:0] PH_FULL = PH_W'(15);

    rx_state_t         state;
    logic [PH_W-1:0]   phase;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              perr_q;
    logic              ferr_q;
    logic              rx_last;

    logic [IDX_W-1:0]  last_idx;
    logic              sample_pt;

    assign last_idx  = cfg_nine ? IDX_W'(DATA_W-1) : IDX_W'(DATA_W-2);
    assign sample_pt = tick16 && (phase == PH_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= '0;
            idx       <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            rx_last   <= 1'b1;
            chr_valid <= 1'b0;
            chr       <= '0;
        end else begin
            chr_valid <= 1'b0;
            if (tick16) rx_last <= rx_s;
            case (state)
                ST_IDLE: begin
                    if (tick16 && rx_last && !rx_s) begin
                        state   <= ST_START;
                        phase   <= '0;
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        perr_q  <= 1'b0;
                        ferr_q  <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick16) begin
                        if (phase == PH_HALF) begin
                            phase <= '0;
                            state <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample_pt) begin
                        phase      <= '0;
                        shreg[idx] <= rx_s;
                        par_acc    <= par_acc ^ rx_s;
                        if (idx == last_idx) state <= cfg_par_en ? ST_PARITY : ST_STOP1;
                        idx <= idx + 1'b1;
                    end else if (tick16) begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (sample_pt) begin
                        phase  <= '0;
                        perr_q <= (rx_s != parity_expect(par_acc, cfg_par_odd));
                        state  <= ST_STOP1;
                    end else if (tick16) begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_STOP1: begin
                    if (sample_pt) begin
                        phase <= '0;
                        if (cfg_two_stop) begin
                            ferr_q <= !rx_s;
                            state  <= ST_STOP2;
                        end else begin
                            chr_valid <= 1'b1;
                            chr       <= '{data: shreg, ferr: !rx_s, perr: perr_q};
                            state     <= ST_IDLE;
                        end
                    end else if (tick16) begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_STOP2: begin
                    if (sample_pt) begin
                        phase     <= '0;
                        chr_valid <= 1'b1;
                        chr       <= '{data: shreg, ferr: ferr_q | !rx_s, perr: perr_q};
                        state     <= ST_IDLE;
                    end else if (tick16) begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A start that reads high at its midpoint must abandon the frame
    assert_start_abort_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick16 && phase == PH_HALF && rx_s) |=> (state == ST_IDLE));

    // A character is announced for one cycle only
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        chr_valid |=> !chr_valid);

    // In 8-bit mode the top data bit of a finished character is zero
    assert_eight_bit_top_R2: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && !cfg_nine && $stable(cfg_nine)) |-> (chr.data[DATA_W-1] == 1'b0));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t push_chr,
    input  logic     pop,
    input  logic     ovr_clr,
    output logic     valid,
    output rx_char_t head,
    output logic     ovr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_char_t       mem [DEPTH];
    logic [PW-1:0]  wptr, rptr;
    logic [CW-1:0]  count;
    logic           pop_ok, room, push_ok, set_ovr;

    assign pop_ok  = pop && (count != '0);
    assign room    = (count < CW'(DEPTH)) || pop_ok;
    assign push_ok = push && !ovr && room;
    assign set_ovr = push && !ovr && !room;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= push_chr;
                wptr      <= bump(wptr);
            end
            if (pop_ok) rptr <= bump(rptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (set_ovr)      ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    assign valid = (count != '0);
    assign head  = mem[rptr];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // Overrun stays until cleared
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    // Nothing is added while the overrun flag is up
    assert_ovr_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rx,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_addr_only,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rd_perr,
    output logic              ovr_flag
);
    logic     rx_s;
    logic     chr_valid;
    rx_char_t chr;
    rx_char_t head;
    logic     keep;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (rx), .dout (rx_s)
    );

    uart_rx_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .tick16       (tick16),
        .rx_s         (rx_s),
        .cfg_nine     (cfg_nine),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .chr_valid    (chr_valid),
        .chr          (chr)
    );

    // Address filter: in 9-bit mode only characters with the top bit set survive
    assign keep = !(cfg_addr_only && cfg_nine && !chr.data[DATA_W-1]);

    uart_rx_hold #(.DEPTH(HOLD_DEPTH)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .push     (chr_valid && keep),
        .push_chr (chr),
        .pop      (rd_en),
        .ovr_clr  (ovr_clr),
        .valid    (rd_valid),
        .head     (head),
        .ovr      (ovr_flag)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;
    assign rd_perr = head.perr;

    // A filtered character leaves the overrun flag untouched
    assert_addr_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && cfg_addr_only && cfg_nine && !chr.data[DATA_W-1] && !ovr_clr)
            |=> (ovr_flag == $past(ovr_flag)));
endmodule

// File: tb/uart_rx_os_bench.sv
module uart_rx_os_bench;
    localparam int TDIV = 4;              // clocks per tick
    localparam int BITC = 16 * TDIV;      // clocks per bit

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic rx = 1'b1;
    logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic cfg_two_stop = 1'b0, cfg_addr_only = 1'b0;
    logic rd_en = 1'b0, ovr_clr = 1'b0;
    logic rd_valid, rd_ferr, rd_perr, ovr_flag;
    logic [8:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    int tdiv_cnt = 0;

    // reference model: held characters as {data, ferr, perr}
    logic [10:0] mq[$];
    bit          m_ovr = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
        tick16   <= (tdiv_cnt == TDIV-1);
    end

    uart_rx_os u_uart_rx_os (
        .clk(clk), .rst(rst), .tick16(tick16), .rx(rx),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_addr_only(cfg_addr_only),
        .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ferr(rd_ferr),
        .rd_perr(rd_perr), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        @(posedge clk); #1 rx = v;
        repeat (BITC - 1) @(posedge clk);
    endtask

    // Sends one frame with the current configuration; bad_stop selects which stop bits are 0
    task automatic send(input logic [8:0] d, input logic flip_par, input logic [1:0] bad_stop);
        int  n = cfg_nine ? 9 : 8;
        logic p = 1'b0;
        logic [8:0] kept = cfg_nine ? d : {1'b0, d[7:0]};
        logic fe;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            hold_bit(d[i]);
            p ^= d[i];
        end
        if (cfg_par_en) hold_bit(p ^ cfg_par_odd ^ flip_par);
        hold_bit(!bad_stop[0]);
        if (cfg_two_stop) hold_bit(!bad_stop[1]);
        fe = bad_stop[0] | (cfg_two_stop & bad_stop[1]);
        hold_bit(1'b1);   // idle gap
        hold_bit(1'b1);
        if (!(cfg_addr_only && cfg_nine && !d[8])) begin
            if (m_ovr || mq.size() >= 2) m_ovr = 1;
            else mq.push_back({kept, fe, cfg_par_en & flip_par});
        end
    endtask

    task automatic compare(input string req);
        #2;
        chk(req, "rd_valid", rd_valid, mq.size() > 0);
        chk(req, "ovr_flag", ovr_flag, m_ovr);
        if (mq.size() > 0) chk(req, "head", {rd_data, rd_ferr, rd_perr}, mq[0]);
    endtask

    task automatic pop();
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic clear_ovr();
        @(posedge clk); #1 ovr_clr = 1'b1;
        @(posedge clk); #1 ovr_clr = 1'b0;
        m_ovr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R9", "reset rd_valid", rd_valid, 0);
        chk("R9", "reset ovr_flag", ovr_flag, 0);
        hold_bit(1'b1);

        // R2: 8-bit, LSB first
        send(9'h0A5, 0, 2'b00); compare("R2"); pop(); compare("R2");
        send(9'h13C, 0, 2'b00); compare("R2"); pop();

        // R3: 9-bit
        cfg_nine = 1'b1;
        send(9'h1C3, 0, 2'b00); compare("R3"); pop();
        send(9'h055, 0, 2'b00); compare("R3"); pop();

        // R4: parity even and odd, good and flipped
        cfg_par_en = 1'b1;
        send(9'h107, 0, 2'b00); compare("R4"); pop();
        send(9'h107, 1, 2'b00); compare("R4"); pop();
        cfg_nine = 1'b0; cfg_par_odd = 1'b1;
        send(9'h0F0, 0, 2'b00); compare("R4"); pop();
        send(9'h0F1, 1, 2'b00); compare("R4"); pop();
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R5: framing, one and two stop bits
        send(9'h081, 0, 2'b01); compare("R5"); pop();
        cfg_two_stop = 1'b1;
        send(9'h042, 0, 2'b10); compare("R5"); pop();
        send(9'h024, 0, 2'b00); compare("R5"); pop();
        cfg_two_stop = 1'b0;

        // R1: short glitch produces nothing
        @(posedge clk); #1 rx = 1'b0;
        repeat (3 * TDIV) @(posedge clk);
        #1 rx = 1'b1;
        repeat (3 * BITC) @(posedge clk);
        compare("R1");
        send(9'h066, 0, 2'b00); compare("R1"); pop();

        // R8: address filter in 9-bit mode
        cfg_nine = 1'b1; cfg_addr_only = 1'b1;
        send(9'h0AA, 0, 2'b00); compare("R8");
        send(9'h1AA, 0, 2'b00); compare("R8"); pop();
        cfg_addr_only = 1'b0; cfg_nine = 1'b0;

        // R6 / R7: fill, order, overrun, drop while flagged, clear
        send(9'h011, 0, 2'b00); compare("R6");
        send(9'h022, 0, 2'b00); compare("R6");
        send(9'h033, 0, 2'b00); compare("R7");
        pop(); compare("R6");
        send(9'h044, 0, 2'b00); compare("R7");
        pop(); compare("R6");
        clear_ovr(); compare("R7");
        send(9'h055, 0, 2'b00); compare("R7"); pop(); compare("R7");

        finish_run();
    end
endmodule